// File: doc/BRIEF.md
# Card Clock Update Handshake

This block produces the card clock for an SD host from a faster source clock. Software programs a staged clock control word (divider, card clock enable, low-power gating) and nothing on the card clock changes. The new settings reach the active divider only when software writes the command word with the start and update-only flags together. The block then copies the staged word into the active settings and clears the start flag. Software polls the command word until start reads zero, then knows the card clock runs with the new settings.

The expected software flow first stops the clock with one update, then loads the new divider with a second, then enables the clock with a third. A divider of N gives a card clock period of 2N source cycles, and a divider of zero passes the source clock straight through. The copy into the active settings only happens while the divided clock is low, and it restarts the low phase, so a change never produces a short pulse. If the wait-previous flag is set, a pending update also waits for the data-busy input to drop. With low-power gating on, the card clock stops whenever no data transfer is busy.

Top module: `card_clk_update`

## Requirements
- R1: After reset both readback words are zero and the card clock stays low.
- R2: The staged control word holds the divider in bits 15:0, the enable in bit 16 and low-power gating in bit 17 (rd_sel=0 reads it back); writing it alone leaves the running card clock unchanged.
- R3: A command write (wr_sel=1) with bit 31 (start) and bit 21 (update-only) set makes bit 31 of the command readback (rd_sel=1) read 1 until the staged settings have become active, after which it reads 0.
- R4: With the clock enabled and a divider N greater than zero, the card clock period is 2N source cycles.
- R5: With the clock enabled and a divider of zero, the card clock period equals one source cycle.
- R6: With the enable cleared in the active settings, the card clock shows no rising edge.
- R7: When the command also has bit 13 (wait-previous) set and data_busy is high, the update stays pending with start reading 1; it completes after data_busy falls.
- R8: With low-power gating active and the clock enabled, the card clock has no edges while data_busy is low and runs at the programmed period while data_busy is high.
- R9: New settings are taken up only while the divided clock is low, and that low phase then lasts at least N full source cycles before the next rising edge.
- R10: A command write with start set but update-only clear is ignored: start reads 0 and the active settings stay as they were.
- R11: A command write while an update is still pending is ignored: the command readback keeps its previous flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 staged control word, 1 command word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 staged control word, 1 command word |
| rd_data | output | 32 | Readback of the selected word |
| data_busy | input | 1 | High while a data transfer is in progress |
| card_clk | output | 1 | Divided card clock |

## Verification
A wrong active setting shows up as a wrong card clock period from the second rising edge after start clears, so the bench measures one full period after each update and compares it with 2N or one source cycle. A start flag stuck high or cleared early shows at once in the command readback, and the bench polls it every cycle. A stuck enable or gating state shows as edges where none may be, or none where they must be, within a few dozen source cycles, which an edge counter detects.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int CMD_START_BIT = 31;
  localparam int CMD_UPD_BIT   = 21;
  localparam int CMD_WAIT_BIT  = 13;

  // Card clock period in source cycles for a divider setting.
  function automatic int unsigned card_period(input int unsigned div);
    return (div == 0) ? 1 : 2 * div;
  endfunction

  typedef struct packed {
    logic lp;
    logic en;
    logic [15:0] div;
  } clk_cfg_t;
endpackage

// File: rtl/ccu_regs.sv
module ccu_regs
  import ccu_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             rd_sel,
  output logic [31:0]      rd_data,
  input  logic             data_busy,
  input  logic             div_low,
  output logic [DIV_W-1:0] stg_div,
  output logic             stg_en,
  output logic             stg_lp,
  output logic [DIV_W-1:0] act_div,
  output logic             act_en,
  output logic             act_lp,
  output logic             start_q,
  output logic             upd_q,
  output logic             wait_q,
  output logic             apply_evt
);
  localparam int EN_POS = DIV_W;
  localparam int LP_POS = DIV_W + 1;

  logic wr_cfg, wr_cmd;
  assign wr_cfg = wr_en && !wr_sel;
  // command word is locked while an update is pending
  assign wr_cmd = wr_en && wr_sel && !start_q;

  assign apply_evt = start_q && !(wait_q && data_busy) && div_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_div <= '0;
      stg_en  <= 1'b0;
      stg_lp  <= 1'b0;
    end else if (wr_cfg) begin
      stg_div <= wr_data[DIV_W-1:0];
      stg_en  <= wr_data[EN_POS];
      stg_lp  <= wr_data[LP_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      upd_q   <= 1'b0;
      wait_q  <= 1'b0;
    end else if (wr_cmd) begin
      start_q <= wr_data[CMD_START_BIT] && wr_data[CMD_UPD_BIT];
      upd_q   <= wr_data[CMD_UPD_BIT];
      wait_q  <= wr_data[CMD_WAIT_BIT];
    end else if (apply_evt) begin
      start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= '0;
      act_en  <= 1'b0;
      act_lp  <= 1'b0;
    end else if (apply_evt) begin
      act_div <= stg_div;
      act_en  <= stg_en;
      act_lp  <= stg_lp;
    end
  end

  logic [31:0] cfg_word, cmd_word;
  always_comb begin
    cfg_word = '0;
    cfg_word[DIV_W-1:0] = stg_div;
    cfg_word[EN_POS]    = stg_en;
    cfg_word[LP_POS]    = stg_lp;
    cmd_word = '0;
    cmd_word[CMD_START_BIT] = start_q;
    cmd_word[CMD_UPD_BIT]   = upd_q;
    cmd_word[CMD_WAIT_BIT]  = wait_q;
  end

  assign rd_data = rd_sel ? cmd_word : cfg_word;
endmodule

// File: rtl/ccu_divider.sv
module ccu_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic [DIV_W-1:0] div,
  output logic             div_q
);
  logic [DIV_W-1:0] cnt;
  logic             last;

  assign last = (cnt == div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (!run || reload || div == '0) begin
      // held low; a reload restarts a full low phase
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (last) begin
      cnt   <= '0;
      div_q <= !div_q;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ccu_bypass_gate.sv
module ccu_bypass_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_en,
  output logic gate_q
);
  // gate changes only while the source clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= pass_en;
  end
endmodule

// File: rtl/card_clk_update.sv
module card_clk_update
  import ccu_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  input  logic        data_busy,
  output logic        card_clk
);
  logic [DIV_W-1:0] stg_div, act_div;
  logic stg_en, stg_lp, act_en, act_lp;
  logic start_q, upd_q, wait_q, apply_evt;
  logic div_q, gate_q, run, bypass;

  ccu_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .data_busy(data_busy), .div_low(!div_q),
    .stg_div(stg_div), .stg_en(stg_en), .stg_lp(stg_lp),
    .act_div(act_div), .act_en(act_en), .act_lp(act_lp),
    .start_q(start_q), .upd_q(upd_q), .wait_q(wait_q),
    .apply_evt(apply_evt)
  );

  // low-power gating stops the clock when no transfer is busy
  assign run    = act_en && !(act_lp && !data_busy);
  assign bypass = (act_div == '0);

  ccu_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .reload(apply_evt),
    .div(act_div), .div_q(div_q)
  );

  ccu_bypass_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pass_en(run && bypass), .gate_q(gate_q)
  );

  assign card_clk = gate_q ? clk : div_q;
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             data_busy,
  input logic [DIV_W-1:0] stg_div,
  input logic             stg_en,
  input logic [DIV_W-1:0] act_div,
  input logic             act_en,
  input logic             start_q,
  input logic             upd_q,
  input logic             wait_q,
  input logic             apply_evt,
  input logic             run,
  input logic             div_q
);
  assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> (act_div == $past(stg_div) && act_en == $past(stg_en)));

  assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && wait_q && data_busy) |=> start_q);

  assert_low_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> !div_q);

  assert_stopped_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !div_q);

  assert_start_needs_upd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> upd_q);

  assert_locked_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && wr_en && wr_sel) |=> $stable(wait_q));
endmodule

bind card_clk_update ccu_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .data_busy(data_busy), .stg_div(stg_div), .stg_en(stg_en),
  .act_div(act_div), .act_en(act_en), .start_q(start_q), .upd_q(upd_q),
  .wait_q(wait_q), .apply_evt(apply_evt), .run(run), .div_q(div_q)
);

// File: tb/card_clk_update_bench.sv
module card_clk_update_bench;
  localparam int CLK_PER = 10;
  localparam int MAX_CYC = 100000;
  localparam logic [31:0] EN = 32'h1 << 16;
  localparam logic [31:0] LP = 32'h1 << 17;
  localparam logic [31:0] UPD_CMD = 32'h8020_2000; // start, update-only, wait-previous
  localparam logic [31:0] UPD_NOWAIT = 32'h8020_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, data_busy = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic card_clk;

  int n_run = 0, n_fail = 0, edge_cnt = 0;
  int exp_q[$];
  string tag_q[$];

  card_clk_update u_card_clk_update (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .data_busy(data_busy), .card_clk(card_clk)
  );

  always #(CLK_PER/2) clk = !clk;
  always @(posedge card_clk) edge_cnt++;

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected period and measures one full card clock period
  initial begin
    forever begin
      time t0;
      wait (exp_q.size() > 0);
      @(posedge card_clk);
      t0 = $time;
      @(posedge card_clk);
      check(tag_q.pop_front(), ($time - t0) / CLK_PER, exp_q.pop_front());
    end
  end

  task automatic expect_period(input int div, input string tag);
    exp_q.push_back((div == 0) ? 1 : 2 * div);
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    rd_sel = sel;
    #1 d = rd_data;
  endtask

  // issue an update and poll start until it clears
  task automatic update(input logic [31:0] cmd, input string tag);
    logic [31:0] d;
    int n = 0;
    wr(1'b1, cmd);
    rd(1'b1, d);
    while (d[31] && n < 200) begin rd(1'b1, d); n++; end
    check(tag, d[31], 0);
  endtask

  task automatic count_edges(input int cycles, input int exp, input string tag);
    int c0;
    @(negedge clk);
    c0 = edge_cnt;
    repeat (cycles) @(negedge clk);
    check(tag, edge_cnt - c0, exp);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(1'b0, d); check("R1 cfg after reset", d, 0);
    rd(1'b1, d); check("R1 cmd after reset", d, 0);
    count_edges(20, 0, "R1 clock idle");

    // bring-up: off, load divider, enable
    wr(1'b0, 32'h0);        update(UPD_CMD, "R3 start clears (off)");
    wr(1'b0, 32'd3);        update(UPD_CMD, "R3 start clears (div)");
    count_edges(30, 0, "R6 divider loaded, still disabled");
    wr(1'b0, EN | 32'd3);   update(UPD_CMD, "R3 start clears (on)");
    rd(1'b0, d); check("R2 cfg fields", d, 32'h0001_0003);
    expect_period(3, "R4 period div 3");

    // staged write alone changes nothing
    wr(1'b0, EN | 32'd5);
    expect_period(3, "R2 staged only");
    update(UPD_CMD, "R3 start clears (div 5)");
    expect_period(5, "R4 R9 period div 5");

    wr(1'b0, EN | 32'd0);   update(UPD_CMD, "R3 start clears (bypass)");
    expect_period(0, "R5 bypass period");
    wr(1'b0, EN | 32'd1);   update(UPD_CMD, "R3 start clears (div 1)");
    expect_period(1, "R4 period div 1");

    wr(1'b0, 32'd1);        update(UPD_CMD, "R3 start clears (disable)");
    count_edges(30, 0, "R6 disabled");

    // start without update-only
    wr(1'b0, EN | 32'd4);
    wr(1'b1, 32'h8000_0000);
    rd(1'b1, d); check("R10 start ignored", d[31], 0);
    count_edges(30, 0, "R10 active unchanged");

    // wait-previous with busy
    data_busy = 1'b1;
    wr(1'b1, UPD_CMD);
    repeat (20) @(negedge clk);
    rd(1'b1, d); check("R7 held while busy", d[31], 1);
    wr(1'b1, 32'h0);
    rd(1'b1, d); check("R11 pending cmd kept", d, UPD_CMD);
    count_edges(20, 0, "R7 not applied while busy");
    data_busy = 1'b0;
    update(32'h0, "R7 completes after busy");
    expect_period(4, "R7 period after release");

    // low-power gating
    wr(1'b0, LP | EN | 32'd2); update(UPD_NOWAIT, "R3 start clears (lp)");
    count_edges(30, 0, "R8 stopped while idle");
    data_busy = 1'b1;
    expect_period(2, "R8 runs while busy");
    data_busy = 1'b0;
    count_edges(30, 0, "R8 stops again");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule